// File: doc/BRIEF.md
# Comparator Interrupt Control Unit

This block is the digital side of a bank of up to four analog comparators. Each comparator has its own 8-bit control register. The register switches the comparator on, allows its interrupt, and picks the edge that raises its flag. It also chooses which sampling strobe clocks the comparator, and carries a 3-bit code that goes out on a select bus to the analog input switches. The raw comparator decisions enter as single bits. A synchronizer brings each one into the block, and this synchronizer advances only on cycles where the chosen strobe is high.

After synchronization, an edge detector compares the settled level with the level it saw on the previous cycle. A match with the chosen sensitivity sets a sticky flag. A shared status word shows every comparator's current level and its pending flag. Software clears a flag by writing 1 to that flag's bit. Each comparator drives its own interrupt request line. Register reads are combinational. A write takes effect at the clock edge on which it is presented.

Top module: `cmp_irq_ctrl`

## Requirements
- R1: After reset, every control register reads 0x00, the status word reads 0x00, and all interrupt requests are low.
- R2: Control register n sits at address n and reads back as written. Its fields are: bit 7 enable, bit 6 interrupt enable, bits 5:4 sensitivity, bit 3 strobe select, and bits 2:0 negative-input code. The code appears on `neg_sel[3n+2:3n]` as soon as the write has been clocked in.
- R3: Sensitivity 00 sets the flag on a change of the synchronized level in either direction.
- R4: Sensitivity 10 sets the flag only on a 1-to-0 change, and sensitivity 11 sets it only on a 0-to-1 change.
- R5: Sensitivity 01 is reserved and never sets the flag.
- R6: Both strobes are held high for this requirement. A raw input change presented before clock edge A shows in the status level bit after edge A+1, and in the flag after edge A+2. The flag is still clear after edge A+1.
- R7: With bit 3 = 1, the synchronizer advances only on cycles where `fast_tick` is high. With bit 3 = 0, it advances only on cycles where `io_tick` is high. While the selected strobe is low, a raw change neither reaches the status word nor sets a flag.
- R8: While a comparator is disabled, its status level bit reads 0 and its flag cannot be set. Enabling it while its input is already high raises no flag.
- R9: Interrupt request n is high exactly when flag n is set and both bit 7 and bit 6 of control register n are 1.
- R10: The status word sits at address NUM_CMP (4 by default). Bits 3:0 hold the levels and bits 7:4 hold the flags, with comparator n at level bit n and flag bit 4+n.
- R11: Writing the status word with bit 4+n = 1 clears flag n, and a 0 in that bit leaves the flag unchanged. If a qualifying edge arrives in the same cycle as the clear, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_tick | input | 1 | Sampling strobe used when strobe select is 0 |
| fast_tick | input | 1 | Sampling strobe used when strobe select is 1 |
| cmp_raw | input | NUM_CMP | Raw comparator decisions, asynchronous |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 8 | Combinational read data |
| neg_sel | output | 3*NUM_CMP | Negative-input select codes, 3 bits per comparator |
| irq | output | NUM_CMP | Per-comparator interrupt requests |

## Verification
With both strobes high, a raw change reaches the status level two edges later and the flag three edges later. The bench changes inputs on falling edges and counts falling edges before it samples: it expects the level on the second and the flag on the third, and it checks that the flag is still clear on the second. Register writes and interrupt gating are sampled one falling edge after the write, because the write is clocked in on the rising edge between. The collision case places the clear write in the exact cycle where the detected edge is pending, which is the second falling edge after the raw change.

// File: rtl/cmp_pkg.sv
package cmp_pkg;

   localparam int CTRL_W = 8;

   typedef enum logic [1:0] {
      SENS_ANY  = 2'b00,
      SENS_RSVD = 2'b01,
      SENS_FALL = 2'b10,
      SENS_RISE = 2'b11
   } sens_e;

   // first member lands in the MSB: enable at bit 7, code at bits 2:0
   typedef struct packed {
      logic       en;
      logic       ie;
      sens_e      sens;
      logic       tick_sel;
      logic [2:0] nsel;
   } ctrl_t;

endpackage

// File: rtl/cmp_sync.sv
module cmp_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic smp_en,
   input  logic d,
   output logic q
);

   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("cmp_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         chain_q <= '0;
      else if (smp_en)
         chain_q <= {chain_q[STAGES-2:0], d};
   end

   assign q = chain_q[STAGES-1];

   AST_SYNC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      !smp_en |=> $stable(q)); // R7

endmodule

// File: rtl/cmp_edge_flag.sv
module cmp_edge_flag
   import cmp_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  en,
   input  sens_e sens,
   input  logic  lvl,
   input  logic  clr,
   output logic  flag
);

   logic hist_q;
   logic flag_q;
   logic rise;
   logic fall;
   logic evt;

   assign rise = lvl & ~hist_q;
   assign fall = ~lvl & hist_q;

   always_comb begin
      unique case (sens)
         SENS_ANY:  evt = rise | fall;
         SENS_FALL: evt = fall;
         SENS_RISE: evt = rise;
         default:   evt = 1'b0;
      endcase
      evt = evt & en;
   end

   // history always follows the level, so enabling never sees a stale edge
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hist_q <= 1'b0;
         flag_q <= 1'b0;
      end else begin
         hist_q <= lvl;
         if (evt)
            flag_q <= 1'b1;
         else if (clr)
            flag_q <= 1'b0;
      end
   end

   assign flag = flag_q;

   AST_RSVD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (sens == SENS_RSVD && !flag_q) |=> !flag_q); // R5
   AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !flag_q) |=> !flag_q); // R8
   AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      evt |=> flag_q); // R11
   AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !evt) |=> !flag_q); // R11

endmodule

// File: rtl/cmp_irq_ctrl.sv
module cmp_irq_ctrl
   import cmp_pkg::*;
#(
   parameter int NUM_CMP     = 4,
   parameter int SYNC_STAGES = 2,
   parameter int ADDR_W      = $clog2(NUM_CMP + 1)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   io_tick,
   input  logic                   fast_tick,
   input  logic [NUM_CMP-1:0]     cmp_raw,
   input  logic                   wr_en,
   input  logic [ADDR_W-1:0]      wr_addr,
   input  logic [7:0]             wr_data,
   input  logic [ADDR_W-1:0]      rd_addr,
   output logic [7:0]             rd_data,
   output logic [3*NUM_CMP-1:0]   neg_sel,
   output logic [NUM_CMP-1:0]     irq
);

   localparam int              FLAG_LSB  = 4;
   localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(NUM_CMP);

   generate
      if (NUM_CMP < 1 || NUM_CMP > 4) begin : g_bad_count
         $error("cmp_irq_ctrl: NUM_CMP must be 1 to 4");
      end
      if ((1 << ADDR_W) <= NUM_CMP) begin : g_bad_addr
         $error("cmp_irq_ctrl: ADDR_W too narrow for status address");
      end
   endgenerate

   ctrl_t              ctrl_q [NUM_CMP];
   logic [NUM_CMP-1:0] lvl;
   logic [NUM_CMP-1:0] lvl_vis;
   logic [NUM_CMP-1:0] flag;
   logic [NUM_CMP-1:0] clr;
   logic [NUM_CMP-1:0] smp_en;
   logic               stat_wr;

   assign stat_wr = wr_en && (wr_addr == STAT_ADDR);

   generate
      for (genvar n = 0; n < NUM_CMP; n++) begin : g_ch
         logic ctrl_wr;
         assign ctrl_wr = wr_en && (wr_addr == ADDR_W'(n));

         always_ff @(posedge clk) begin
            if (!rst_n)
               ctrl_q[n] <= '0;
            else if (ctrl_wr)
               ctrl_q[n] <= ctrl_t'(wr_data);
         end

         assign smp_en[n] = ctrl_q[n].tick_sel ? fast_tick : io_tick;
         assign clr[n]    = stat_wr & wr_data[FLAG_LSB+n];

         cmp_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk    (clk),
            .rst_n  (rst_n),
            .smp_en (smp_en[n]),
            .d      (cmp_raw[n]),
            .q      (lvl[n])
         );

         cmp_edge_flag u_edge (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (ctrl_q[n].en),
            .sens  (ctrl_q[n].sens),
            .lvl   (lvl[n]),
            .clr   (clr[n]),
            .flag  (flag[n])
         );

         assign lvl_vis[n]         = lvl[n] & ctrl_q[n].en;
         assign irq[n]             = flag[n] & ctrl_q[n].en & ctrl_q[n].ie;
         assign neg_sel[3*n +: 3]  = ctrl_q[n].nsel;

         AST_IRQ_OFF_AFTER_DISABLE: assert property (@(posedge clk) disable iff (!rst_n)
            (ctrl_wr && !wr_data[7]) |=> !irq[n]); // R9
         AST_LEVEL_HIDDEN_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
            (ctrl_wr && !wr_data[7]) |=> !lvl_vis[n]); // R8
      end
   endgenerate

   always_comb begin
      rd_data = '0;
      if (rd_addr == STAT_ADDR) begin
         rd_data[NUM_CMP-1:0]                 = lvl_vis;
         rd_data[FLAG_LSB +: NUM_CMP]         = flag;
      end else begin
         for (int k = 0; k < NUM_CMP; k++)
            if (rd_addr == ADDR_W'(k))
               rd_data = ctrl_q[k];
      end
   end

endmodule

// File: tb/cmp_irq_ctrl_tb.sv
module cmp_irq_ctrl_tb_top;

   localparam int NC = 4;
   localparam int AW = 3;
   localparam logic [AW-1:0] STAT = 3'd4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          io_tick = 1'b1;
   logic          fast_tick = 1'b1;
   logic [NC-1:0] cmp_raw = '0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [7:0]    wr_data = '0;
   logic [AW-1:0] rd_addr = '0;
   logic [7:0]    rd_data;
   logic [3*NC-1:0] neg_sel;
   logic [NC-1:0] irq;

   int n_chk = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   cmp_irq_ctrl #(.NUM_CMP(NC)) dut_i (
      .clk(clk), .rst_n(rst_n), .io_tick(io_tick), .fast_tick(fast_tick),
      .cmp_raw(cmp_raw), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .neg_sel(neg_sel), .irq(irq)
   );

   // {sens[1:0], start, end, expected flag, channel[1:0]}
   localparam logic [6:0] VEC [0:7] = '{
      7'b00_0_1_1_00, 7'b00_1_0_1_01, 7'b10_1_0_1_10, 7'b10_0_1_0_11,
      7'b11_0_1_1_00, 7'b11_1_0_0_01, 7'b01_0_1_0_10, 7'b01_1_0_0_11
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [AW-1:0] a, output logic [7:0] v);
      rd_addr = a;
      #0.5;
      v = rd_data;
   endtask

   initial begin
      logic [7:0] v;
      tick(3);
      rst_n = 1'b1;
      tick(1);

      // R1 reset state
      for (int a = 0; a < 5; a++) begin
         rd(AW'(a), v);
         chk("R1 register after reset", v, 0);
      end
      chk("R1 irq after reset", irq, 0);

      // table walk: R3 / R4 / R5 with R6 latency and R10 layout
      for (int i = 0; i < 8; i++) begin
         logic [1:0] sens, ch;
         logic st, en_v, ex;
         string tag;
         {sens, st, en_v, ex, ch} = VEC[i];
         tag = (sens == 2'b00) ? "R3" : (sens == 2'b01) ? "R5" : "R4";
         cmp_raw[ch] = st;
         tick(4);
         wr(AW'(ch), {1'b1, 1'b1, sens, 1'b0, 1'b0, ch});
         wr(STAT, 8'hF0);
         cmp_raw[ch] = en_v;
         tick(2);
         rd(STAT, v);
         chk("R6 level after two edges", v[ch], en_v);
         chk("R6 flag clear after two edges", v[4+ch], 0);
         tick(1);
         rd(STAT, v);
         chk({tag, " flag after three edges"}, v[4+ch], ex);
         chk({tag, " irq follows flag"}, irq[ch], ex);
         wr(AW'(ch), 8'h00);
         wr(STAT, 8'hF0);
      end

      // R2 layout and select bus
      wr(3'd1, 8'h35);
      rd(3'd1, v);
      chk("R2 readback", v, 8'h35);
      chk("R2 neg_sel field", neg_sel[5:3], 3'd5);
      wr(3'd1, 8'h00);

      // R9 gating by interrupt enable
      wr(3'd0, 8'h80);
      cmp_raw[0] = ~cmp_raw[0];
      tick(3);
      rd(STAT, v);
      chk("R9 flag set with ie=0", v[4], 1);
      chk("R9 irq low with ie=0", irq[0], 0);
      wr(3'd0, 8'hC0);
      chk("R9 irq high with en and ie", irq[0], 1);
      wr(3'd0, 8'h40);
      chk("R9 irq low when disabled", irq[0], 0);

      // R11 write-one-to-clear and collision
      wr(STAT, 8'h00);
      rd(STAT, v);
      chk("R11 zero write keeps flag", v[4], 1);
      wr(STAT, 8'h10);
      rd(STAT, v);
      chk("R11 one clears flag", v[4], 0);
      wr(3'd0, 8'hC0);
      cmp_raw[0] = ~cmp_raw[0];
      tick(3);
      cmp_raw[0] = ~cmp_raw[0];
      tick(2);
      wr(STAT, 8'h10);
      rd(STAT, v);
      chk("R11 event beats clear", v[4], 1);
      wr(STAT, 8'h10);
      wr(3'd0, 8'h00);

      // R8 disabled comparator and clean enable
      cmp_raw[1] = 1'b1;
      tick(4);
      rd(STAT, v);
      chk("R8 level hidden while off", v[1], 0);
      chk("R8 no flag while off", v[5], 0);
      wr(3'd1, 8'hC0);
      tick(3);
      rd(STAT, v);
      chk("R8 no flag on enable", v[5], 0);
      chk("R10 level bit 1 visible", v[1], 1);

      // R7 strobe select
      cmp_raw[2] = 1'b0;
      tick(4);
      io_tick = 1'b0;
      wr(3'd2, 8'hC8);
      cmp_raw[2] = 1'b1;
      tick(3);
      rd(STAT, v);
      chk("R7 fast strobe samples", v[6], 1);
      wr(STAT, 8'h40);
      wr(3'd2, 8'hC0);
      cmp_raw[2] = 1'b0;
      tick(5);
      rd(STAT, v);
      chk("R7 io strobe low holds level", v[2], 1);
      chk("R7 io strobe low no flag", v[6], 0);
      io_tick = 1'b1;
      tick(3);
      rd(STAT, v);
      chk("R7 io strobe high samples", v[6], 1);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL R1 watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule